// File: doc/BRIEF.md
# Transition-Limited Bus Inversion Codec

This block sits between a core and a wide, quad-pumped parallel data bus. It cuts the switching activity on that bus. The 64-bit bus is divided into four 16-bit lanes. For every beat, each lane is compared with the level its wires were last driven to. If sending the lane as-is would flip more than half of its wires, the lane is sent complemented instead, and that lane's inversion flag is asserted. Wire data and flags use active-low signalling: a logic 1 is a low wire, and an asserted flag is a 0.

One bus clock carries four beats. The transmit side therefore takes a whole packet of four 64-bit beats per accepted transfer. It encodes the beats as a chain, so beat 0 is measured against the last beat of the previous packet and each later beat is measured against the beat before it. The encoded wires and flags are registered and held until the next accepted packet. The receive side is a separate, purely combinational path that turns wire data and flags back into true data. The bench loops the transmit pins back into it.

Top module: `dbi_codec`

## Requirements
- R1: Lane l of beat b occupies bits `b*64 + l*16 + 15 : b*64 + l*16` of every data and wire bus. Its flag is bit `b*4 + l` of the flag buses. Beat 0 is the first beat sent.
- R2: A lane whose uninverted wire value (the bitwise complement of its true data) differs from its reference in 9 or more of its 16 bits is sent inverted. Its wire bits then equal the true data bits and its flag is 0.
- R3: A lane with 8 or fewer differing bits is sent uninverted. Its wire bits equal the complement of the true data and its flag is 1. Exactly 8 differences stay uninverted.
- R4: The reference for beat 0 is the wire value last driven in beat 3 of the previous accepted packet, after any inversion. The reference for beat b>0 is the wire value chosen for beat b-1 of the same packet.
- R5: Between any two consecutively driven beats, no lane changes more than 8 wires. This includes the step across packet boundaries.
- R6: While reset is high, `tx_wire` is all ones, `tx_flag_n` is all ones, `tx_valid` is 0 and `in_ready` is 0. `in_ready` becomes 1 at the first clock edge after reset is released.
- R7: In a cycle without `in_valid && in_ready`, the wire and flag outputs and the history keep their values, and `tx_valid` is 0 in the next cycle.
- R8: `rx_data` equals `rx_wire` XOR each lane's flag bit replicated over its 16 bits. It is combinational, with no clock involved.
- R9: A packet accepted at one clock edge appears on `tx_wire`/`tx_flag_n` after that edge, with `tx_valid` high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet can be taken |
| in_data | input | 256 | Four beats of true data |
| tx_valid | output | 1 | New packet on the wires this cycle |
| tx_wire | output | 256 | Encoded active-low wire data, four beats |
| tx_flag_n | output | 16 | Active-low inversion flags, four per beat |
| rx_wire | input | 256 | Received wire data |
| rx_flag_n | input | 16 | Received inversion flags |
| rx_data | output | 256 | Restored true data |

## Verification
The only internal state is the wire history, so any corruption of it shows up on the very next accepted packet. Beat 0 then carries the wrong flag decision, and the change between the previous beat 3 and the new beat 0 can exceed 8 wires. The chained reference inside a packet is exposed the same cycle, on beats 1 to 3. Idle gaps and back-to-back packets are mixed in random streams. Every packet is compared against a bench model, decoded through the loop-back and checked for the 8-wire bound. The exact 8/9 boundary and the reset value of the history are checked directly.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int DEF_LANE_W = 16;
    localparam int DEF_LANES  = 4;
    localparam int DEF_BEATS  = 4;

    // population count over a zero-extended vector of up to 64 bits
    function automatic logic [6:0] ones64(input logic [63:0] v);
        logic [6:0] n;
        n = '0;
        for (int i = 0; i < 64; i++) begin
            n = n + 7'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc #(
    parameter int LANE_W = dbi_pkg::DEF_LANE_W
) (
    input  logic [LANE_W-1:0] data_i,
    input  logic [LANE_W-1:0] ref_i,
    output logic [LANE_W-1:0] wire_o,
    output logic              inv_n_o
);
    localparam int CW     = $clog2(LANE_W + 1);
    localparam int THRESH = LANE_W / 2;

    logic [LANE_W-1:0] cand;
    logic [LANE_W-1:0] diff;
    logic [CW-1:0]     cnt;
    logic              flip;

    always_comb begin
        cand = ~data_i;
        diff = cand ^ ref_i;
        cnt  = '0;
        for (int i = 0; i < LANE_W; i++) begin
            cnt = cnt + CW'(diff[i]);
        end
        flip    = (cnt > CW'(THRESH));
        wire_o  = flip ? data_i : cand;
        inv_n_o = ~flip;
    end

    // R5: the chosen wire value never moves more than half the lane
    logic [CW-1:0] moved;
    always_comb begin
        moved = '0;
        for (int i = 0; i < LANE_W; i++) begin
            moved = moved + CW'(wire_o[i] ^ ref_i[i]);
        end
        p_lane_bound_r5: assert (moved <= CW'(THRESH) || $isunknown(data_i) || $isunknown(ref_i));
    end

endmodule

// File: rtl/dbi_beat_enc.sv
module dbi_beat_enc #(
    parameter int LANE_W = dbi_pkg::DEF_LANE_W,
    parameter int LANES  = dbi_pkg::DEF_LANES
) (
    input  logic [LANES*LANE_W-1:0] data_i,
    input  logic [LANES*LANE_W-1:0] ref_i,
    output logic [LANES*LANE_W-1:0] wire_o,
    output logic [LANES-1:0]        flag_n_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dbi_lane_enc #(.LANE_W(LANE_W)) u_lane (
            .data_i  (data_i[l*LANE_W +: LANE_W]),
            .ref_i   (ref_i[l*LANE_W +: LANE_W]),
            .wire_o  (wire_o[l*LANE_W +: LANE_W]),
            .inv_n_o (flag_n_o[l])
        );
    end

endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec #(
    parameter int LANE_W = dbi_pkg::DEF_LANE_W
) (
    input  logic [LANE_W-1:0] wire_i,
    input  logic              flag_n_i,
    output logic [LANE_W-1:0] data_o
);
    // uninverted: wire = ~data, flag 1; inverted: wire = data, flag 0
    always_comb begin
        data_o = wire_i ^ {LANE_W{flag_n_i}};
    end

endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
    parameter int LANE_W = dbi_pkg::DEF_LANE_W,
    parameter int LANES  = dbi_pkg::DEF_LANES,
    parameter int BEATS  = dbi_pkg::DEF_BEATS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [BEATS*LANES*LANE_W-1:0] in_data,
    output logic                          tx_valid,
    output logic [BEATS*LANES*LANE_W-1:0] tx_wire,
    output logic [BEATS*LANES-1:0]        tx_flag_n,
    input  logic [BEATS*LANES*LANE_W-1:0] rx_wire,
    input  logic [BEATS*LANES-1:0]        rx_flag_n,
    output logic [BEATS*LANES*LANE_W-1:0] rx_data
);
    localparam int BUS_W = LANES * LANE_W;
    localparam int TOT_W = BEATS * BUS_W;
    localparam int FLG_W = BEATS * LANES;
    localparam int LAST  = (BEATS - 1) * BUS_W;

    typedef struct packed {
        logic [TOT_W-1:0] wbits;
        logic [FLG_W-1:0] flag_n;
        logic             out_valid;
        logic             ready;
    } tx_state_t;

    localparam tx_state_t RESET_ST = '{wbits: '1, flag_n: '1, out_valid: 1'b0, ready: 1'b0};

    tx_state_t st_d, st_q;

    logic [TOT_W-1:0] enc_wire;
    logic [FLG_W-1:0] enc_flag;

    // chained encoders: beat 0 refers to the held last beat
    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        logic [BUS_W-1:0] ref_b;
        if (b == 0) begin : g_first
            assign ref_b = st_q.wbits[LAST +: BUS_W];
        end else begin : g_next
            assign ref_b = enc_wire[(b-1)*BUS_W +: BUS_W];
        end
        dbi_beat_enc #(.LANE_W(LANE_W), .LANES(LANES)) u_beat (
            .data_i   (in_data[b*BUS_W +: BUS_W]),
            .ref_i    (ref_b),
            .wire_o   (enc_wire[b*BUS_W +: BUS_W]),
            .flag_n_o (enc_flag[b*LANES +: LANES])
        );
    end

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.ready     = 1'b1;
        if (in_valid && st_q.ready) begin
            st_d.wbits     = enc_wire;
            st_d.flag_n    = enc_flag;
            st_d.out_valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = st_q.ready;
    assign tx_valid  = st_q.out_valid;
    assign tx_wire   = st_q.wbits;
    assign tx_flag_n = st_q.flag_n;

    // receive side
    for (genvar k = 0; k < FLG_W; k++) begin : g_dec
        dbi_lane_dec #(.LANE_W(LANE_W)) u_dec (
            .wire_i   (rx_wire[k*LANE_W +: LANE_W]),
            .flag_n_i (rx_flag_n[k]),
            .data_o   (rx_data[k*LANE_W +: LANE_W])
        );
    end

    // ---------------- assertions ----------------
    p_reset_idle_r6: assert property (@(posedge clk)
        rst |=> (tx_wire == '1 && tx_flag_n == '1 && !tx_valid && !in_ready));

    p_ready_release_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> in_ready);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(tx_wire) && $stable(tx_flag_n) && !tx_valid));

    p_accept_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> tx_valid);

    for (genvar b = 0; b < BEATS; b++) begin : g_chk
        for (genvar l = 0; l < LANES; l++) begin : g_ln
            if (b == 0) begin : g_edge
                p_packet_edge_r5: assert property (@(posedge clk) disable iff (rst)
                    tx_valid |-> (dbi_pkg::ones64(64'(tx_wire[l*LANE_W +: LANE_W]
                        ^ $past(tx_wire[LAST + l*LANE_W +: LANE_W]))) <= 7'(LANE_W/2)));
            end else begin : g_inner
                p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
                    tx_valid |-> (dbi_pkg::ones64(64'(tx_wire[b*BUS_W + l*LANE_W +: LANE_W]
                        ^ tx_wire[(b-1)*BUS_W + l*LANE_W +: LANE_W])) <= 7'(LANE_W/2)));
            end
        end
    end

endmodule

// File: tb/dbi_codec_tb.sv
module dbi_codec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 16;
    localparam int LN = 4;
    localparam int BT = 4;
    localparam int TW = LW * LN * BT;
    localparam int FW = LN * BT;
    localparam int NT = 8;

    // hand-worked sequence starting from reset history (all ones)
    localparam logic [15:0] T_DATA [NT] = '{16'h0000, 16'hFFFF, 16'h00FF, 16'h01FF,
                                           16'hFE00, 16'h00FF, 16'h0000, 16'h01FF};
    localparam logic [15:0] T_WIRE [NT] = '{16'hFFFF, 16'hFFFF, 16'hFF00, 16'hFE00,
                                           16'hFE00, 16'hFF00, 16'hFFFF, 16'h01FF};
    localparam logic        T_FN   [NT] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [TW-1:0] in_data = '0;
    logic tx_valid;
    logic [TW-1:0] tx_wire;
    logic [FW-1:0] tx_flag_n;
    logic lb = 1'b1;
    logic [TW-1:0] rx_wire_dir = '0;
    logic [FW-1:0] rx_flag_dir = '0;
    logic [TW-1:0] rx_wire;
    logic [FW-1:0] rx_flag_n;
    logic [TW-1:0] rx_data;

    assign rx_wire   = lb ? tx_wire : rx_wire_dir;
    assign rx_flag_n = lb ? tx_flag_n : rx_flag_dir;

    dbi_codec u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .tx_valid(tx_valid), .tx_wire(tx_wire), .tx_flag_n(tx_flag_n),
        .rx_wire(rx_wire), .rx_flag_n(rx_flag_n), .rx_data(rx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [TW-1:0] m_hist;
    logic [TW-1:0] prev_wire;

    task automatic check(input logic ok, input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench model built from R2/R3/R4; m_hist holds the last driven beat in the top slice
    function automatic void model(input logic [TW-1:0] d, output logic [TW-1:0] w, output logic [FW-1:0] f);
        logic [15:0] r [LN];
        logic [15:0] c;
        for (int l = 0; l < LN; l++) r[l] = m_hist[(BT-1)*64 + l*16 +: 16];
        for (int b = 0; b < BT; b++) begin
            for (int l = 0; l < LN; l++) begin
                c = ~d[b*64 + l*16 +: 16];
                if ($countones(c ^ r[l]) > 8) begin
                    r[l] = d[b*64 + l*16 +: 16];
                    f[b*LN + l] = 1'b0;
                end else begin
                    r[l] = c;
                    f[b*LN + l] = 1'b1;
                end
                w[b*64 + l*16 +: 16] = r[l];
            end
        end
        m_hist = w;
    endfunction

    function automatic int worst_step(input logic [TW-1:0] w, input logic [TW-1:0] pw);
        int m = 0;
        int n;
        for (int b = 0; b < BT; b++) begin
            for (int l = 0; l < LN; l++) begin
                if (b == 0) n = $countones(w[l*16 +: 16] ^ pw[(BT-1)*64 + l*16 +: 16]);
                else        n = $countones(w[b*64 + l*16 +: 16] ^ w[(b-1)*64 + l*16 +: 16]);
                if (n > m) m = n;
            end
        end
        return m;
    endfunction

    // verify outputs of one accepted packet, sampled at the negedge after acceptance
    task automatic verify(input logic [TW-1:0] d, input string tag);
        logic [TW-1:0] ew;
        logic [FW-1:0] ef;
        model(d, ew, ef);
        check(tx_valid === 1'b1, "R9 tx_valid after accept", TW'(tx_valid), TW'(1));
        check(tx_wire === ew, {tag, " wire"}, tx_wire, ew);
        check(tx_flag_n === ef, {tag, " flags"}, TW'(tx_flag_n), TW'(ef));
        check(rx_data === d, "R8 loopback decode", rx_data, d);
        check(worst_step(tx_wire, prev_wire) <= 8, "R5 toggle bound",
              TW'(worst_step(tx_wire, prev_wire)), TW'(8));
        prev_wire = tx_wire;
    endtask

    task automatic send(input logic [TW-1:0] d, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        verify(d, tag);
        @(negedge clk);
        check(tx_valid === 1'b0, "R9 single-cycle valid", TW'(tx_valid), TW'(0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tx_wire === '1 && tx_flag_n === '1, "R6 reset idle bus", tx_wire, '1);
        check(tx_valid === 1'b0 && in_ready === 1'b0, "R6 reset handshake",
              TW'({tx_valid, in_ready}), TW'(0));
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R6 ready after release", TW'(in_ready), TW'(1));
        m_hist    = '1;
        prev_wire = '1;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [TW-1:0] held_w;
        logic [FW-1:0] held_f;
        logic [TW-1:0] d;
        logic [TW-1:0] pend;
        logic pend_v;

        do_reset();

        // table of hand-derived decisions (R2, R3, exact-8 boundary, R4 history)
        for (int i = 0; i < NT; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = {16{T_DATA[i]}};
            @(negedge clk);
            in_valid = 1'b0;
            check(tx_wire === {16{T_WIRE[i]}}, (T_FN[i] ? "R3 table wire" : "R2 table wire"),
                  tx_wire, {16{T_WIRE[i]}});
            check(tx_flag_n === {16{T_FN[i]}}, (T_FN[i] ? "R3 table flag" : "R2 table flag"),
                  TW'(tx_flag_n), TW'({16{T_FN[i]}}));
            check(rx_data === {16{T_DATA[i]}}, "R8 table decode", rx_data, {16{T_DATA[i]}});
            begin
                logic [TW-1:0] mw;
                logic [FW-1:0] mf;
                model({16{T_DATA[i]}}, mw, mf);
            end
            prev_wire = tx_wire;
        end

        // R1 lane placement: only lane 2 inverts (history is 01FF in every lane)
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {4{16'h0000, 16'h01FF, 16'h0000, 16'h0000}};
        @(negedge clk);
        in_valid = 1'b0;
        check(tx_flag_n === {4{4'b1011}}, "R1 lane flag position", TW'(tx_flag_n), TW'({4{4'b1011}}));
        check(tx_wire === {4{16'hFFFF, 16'h01FF, 16'hFFFF, 16'hFFFF}}, "R1 lane wire position",
              tx_wire, {4{16'hFFFF, 16'h01FF, 16'hFFFF, 16'hFFFF}});
        begin
            logic [TW-1:0] mw;
            logic [FW-1:0] mf;
            model(in_data, mw, mf);
        end
        prev_wire = tx_wire;

        // R4 chain inside one packet: alternating beats
        send({16'h0F0F, 16'h0000, 16'hFFFF, 16'h00FF,
              16'hF0F0, 16'hFFFF, 16'h0000, 16'h01FF,
              16'h0F0F, 16'h0000, 16'hFFFF, 16'h00FF,
              16'hF0F0, 16'hFFFF, 16'h0000, 16'h01FF}, "R4 chained beats");

        // R7 idle cycles hold wires and history
        held_w = tx_wire;
        held_f = tx_flag_n;
        repeat (3) @(negedge clk);
        check(tx_wire === held_w && tx_flag_n === held_f, "R7 idle hold", tx_wire, held_w);
        check(tx_valid === 1'b0, "R7 idle no valid", TW'(tx_valid), TW'(0));
        send({16{16'h3C5A}}, "R7 after idle");

        // random stream with gaps and back-to-back packets
        pend_v = 1'b0;
        pend   = '0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pend_v) verify(pend, "R4 random");
            else check(tx_valid === 1'b0, "R7 gap no valid", TW'(tx_valid), TW'(0));
            for (int k = 0; k < TW/32; k++) d[k*32 +: 32] = $urandom;
            if (i % 5 == 1) d[15:0] = 16'h0000;
            pend_v   = ($urandom % 4) != 0;
            pend     = d;
            in_valid = pend_v;
            in_data  = d;
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (pend_v) verify(pend, "R4 random");

        // R8 decoder driven directly
        lb = 1'b0;
        rx_wire_dir = {16{16'h1234}};
        rx_flag_dir = 16'hA5A5;
        #1;
        begin
            logic [TW-1:0] e;
            for (int k = 0; k < FW; k++) e[k*16 +: 16] = 16'h1234 ^ {16{rx_flag_dir[k]}};
            check(rx_data === e, "R8 direct decode", rx_data, e);
        end
        lb = 1'b1;

        // R6 reset mid-run then fresh history
        do_reset();
        send({16{16'hFFFF}}, "R6 post-reset history");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule